// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Coder

This block is the digital front of a serial video transmitter. On each parallel clock it takes one input word and turns it into a group of serial bits. A word is 10 bits in multiplexed mode, or a pair of 10-bit words in demultiplexed mode. In coding mode every bit first passes a self-synchronizing scrambler with generator x^9 + x^4 + 1 and then an NRZ-to-NRZI stage with generator x + 1. In data-through mode the bits are only put in serial order.

The serial stream comes out as a group of up to 20 bits per parallel clock, with the earliest bit in position 0. A downstream shifter can therefore run from a multiplied clock, while this block stays fully synchronous to the parallel clock. The scrambler history and the NRZI level carry across words and across changes of width. They are frozen while data-through mode is selected.

Top module: `vid_scramble_tx`

## Requirements
- R1: While `rstN` is low, `serOut` and `serWide` are 0. Reset clears the scrambler history and the NRZI level to zero, so all-zero input coded right after reset gives an all-zero output.
- R2: In coding mode (`codeEn`=1) each scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9]. Here d is the serial input bit and s holds past scrambled bits, counted over the whole serial stream.
- R3: In coding mode each output bit is the NRZI level y[n] = y[n-1] XOR s[n]. The level toggles on a scrambled 1 and holds on a 0.
- R4: Serial order puts stream bit k in `serOut[k]`, with bit 0 sent first. Each word is sent LSB first. The group for a word drawn on clock edge t appears right after edge t: one register of latency.
- R5: With `wideMode`=1, `dataIn[9:0]` (chroma) forms stream bits 0..9 and `dataIn[19:10]` (luma) forms bits 10..19. `serWide` is then 1.
- R6: With `wideMode`=0, the word is `dataIn[19:10]` in stream bits 0..9. `dataIn[9:0]` has no effect. `serOut[19:10]` is 0 and `serWide` is 0.
- R7: With `codeEn`=0, `serOut` carries the stream bits of R5 or R6 unaltered, with no scrambling and no NRZI coding.
- R8: Words sent with `codeEn`=0 leave the scrambler history and the NRZI level unchanged. Coding resumes from the state left by the last coded word.
- R9: Scrambler and NRZI state run continuously across consecutive words and across changes of `wideMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| codeEn | input | 1 | 1: scramble and NRZI code; 0: data-through |
| wideMode | input | 1 | 1: 20-bit demultiplexed input; 0: 10-bit multiplexed input |
| dataIn | input | 20 | Parallel input word (luma on [19:10], chroma on [9:0]) |
| serOut | output | 20 | Serial bit group, bit 0 sent first |
| serWide | output | 1 | 1 when all 20 bits of `serOut` are valid, 0 when only [9:0] are |

## Verification
Every result lands one parallel clock after its word is presented. This covers the coded bits, the data-through bits, the `serWide` flag and the zeroed upper half. The bench drives a word on a falling edge and compares the outputs on the next falling edge, which is half a period after the rising edge that registers them. A reference model in the bench advances bit by bit in stream order, and advances only for coded words. Because of this, state carried across words, width changes and data-through gaps shows up in the very next coded group. The reset values are read while reset is held, before the first rising edge that leaves it.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  // Strobes from the mode control to the coding datapath.
  typedef struct packed {
    logic codeOn;   // scramble and NRZI encode this word
    logic wideOn;   // all lanes of the input word are active
  } vscStrobes_t;

endpackage

// File: rtl/vsc_ctrl.sv
module vsc_ctrl
  import vsc_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int LANES  = 2,
  localparam int SER_W = WORD_W * LANES
) (
  input  logic              codeEn,
  input  logic              wideMode,
  output vscStrobes_t       stb,
  output logic [SER_W-1:0]  bitMask
);

  always_comb begin
    stb.codeOn = codeEn;
    stb.wideOn = wideMode;
  end

  // One mask bit per serial position: the first lane is always active,
  // the remaining lanes only in wide mode.
  for (genvar i = 0; i < SER_W; i++) begin : g_mask
    if (i < WORD_W) begin : g_first
      assign bitMask[i] = 1'b1;
    end else begin : g_rest
      assign bitMask[i] = wideMode;
    end
  end

  // R6: narrow mode enables exactly one lane's worth of bits.
  always_comb begin
    if (!wideMode) begin
      a_narrow_mask_r6: assert ($countones(bitMask) == WORD_W);
    end
  end

endmodule

// File: rtl/vsc_datapath.sv
module vsc_datapath
  import vsc_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LANES    = 2,
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 9,
  localparam int SER_W   = WORD_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  vscStrobes_t       stb,
  input  logic [SER_W-1:0]  bitMask,
  input  logic [SER_W-1:0]  dataIn,
  output logic [SER_W-1:0]  serOut,
  output logic              serWide
);

  // Stream assembly: wide takes the word as is (low lane first),
  // narrow takes only the top lane and places it at stream position 0.
  logic [SER_W-1:0] stream;
  always_comb begin
    stream = '0;
    if (stb.wideOn) begin
      stream = dataIn;
    end else begin
      stream[WORD_W-1:0] = dataIn[SER_W-1 -: WORD_W];
    end
  end

  // Coding state: histQ[0] is the newest scrambled bit.
  logic [TAP_FAR-1:0] histQ;
  logic               lvlQ;
  logic               outCode;

  logic [TAP_FAR-1:0] histChain [0:SER_W];
  logic               lvlChain  [0:SER_W];
  logic [SER_W-1:0]   scrBit;
  logic [SER_W-1:0]   nrziBit;

  assign histChain[0] = histQ;
  assign lvlChain[0]  = lvlQ;

  for (genvar i = 0; i < SER_W; i++) begin : g_bit
    assign scrBit[i] = stream[i] ^ histChain[i][TAP_NEAR-1] ^ histChain[i][TAP_FAR-1];
    assign histChain[i+1] = bitMask[i] ? {histChain[i][TAP_FAR-2:0], scrBit[i]} : histChain[i];
    assign lvlChain[i+1]  = bitMask[i] ? (lvlChain[i] ^ scrBit[i]) : lvlChain[i];
    assign nrziBit[i]     = bitMask[i] & lvlChain[i+1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ   <= '0;
      lvlQ    <= 1'b0;
      serOut  <= '0;
      serWide <= 1'b0;
      outCode <= 1'b0;
    end else begin
      if (stb.codeOn) begin
        histQ <= histChain[SER_W];
        lvlQ  <= lvlChain[SER_W];
      end
      serOut  <= stb.codeOn ? nrziBit : stream;
      serWide <= stb.wideOn;
      outCode <= stb.codeOn;
    end
  end

  // R8: data-through words leave the coding state untouched.
  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.codeOn |=> ($stable(histQ) && $stable(lvlQ)));

  // R6: in narrow mode the upper part of the group is zero.
  p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !serWide |-> (serOut[SER_W-1:WORD_W] == '0));

  // R3: the held NRZI level equals the last coded bit sent.
  p_level_tracks_r3: assert property (@(posedge clk) disable iff (!rstN)
    outCode |-> (lvlQ == (serWide ? serOut[SER_W-1] : serOut[WORD_W-1])));

endmodule

// File: rtl/vid_scramble_tx.sv
module vid_scramble_tx
  import vsc_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LANES    = 2,
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 9,
  localparam int SER_W   = WORD_W * LANES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             codeEn,
  input  logic             wideMode,
  input  logic [SER_W-1:0] dataIn,
  output logic [SER_W-1:0] serOut,
  output logic             serWide
);

  vscStrobes_t      stb;
  logic [SER_W-1:0] bitMask;

  vsc_ctrl #(
    .WORD_W (WORD_W),
    .LANES  (LANES)
  ) u_ctrl (
    .codeEn   (codeEn),
    .wideMode (wideMode),
    .stb      (stb),
    .bitMask  (bitMask)
  );

  vsc_datapath #(
    .WORD_W   (WORD_W),
    .LANES    (LANES),
    .TAP_NEAR (TAP_NEAR),
    .TAP_FAR  (TAP_FAR)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bitMask (bitMask),
    .dataIn  (dataIn),
    .serOut  (serOut),
    .serWide (serWide)
  );

  // One cycle after reset there is a valid previous cycle to look at.
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R7: narrow data-through delivers the top lane unaltered.
  p_bypass_narrow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!codeEn && !wideMode)) |->
      (serOut[WORD_W-1:0] == $past(dataIn[SER_W-1 -: WORD_W])));

  // R5: the width flag follows the width of the word it goes with.
  p_wide_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (serWide == $past(wideMode)));

endmodule

// File: tb/vid_scramble_tx_tb.sv
module vid_scramble_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        codeEn = 1'b0;
  logic        wideMode = 1'b0;
  logic [19:0] dataIn = '0;
  logic [19:0] serOut;
  logic        serWide;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // Reference model state: mPast[0] is the newest scrambled bit.
  logic [8:0] mPast;
  logic       mLvl;

  vid_scramble_tx u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .codeEn   (codeEn),
    .wideMode (wideMode),
    .dataIn   (dataIn),
    .serOut   (serOut),
    .serWide  (serWide)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mPast = '0;
    mLvl  = 1'b0;
  endtask

  // Expected group for one word, per R2..R9; advances the model if coded.
  task automatic modelWord(input logic c, input logic w, input logic [19:0] d,
                           output logic [19:0] e);
    logic [19:0] str;
    logic s;
    int n;
    n = w ? 20 : 10;
    str = w ? d : {10'b0, d[19:10]};
    e = '0;
    if (!c) begin
      e = str;
    end else begin
      for (int k = 0; k < n; k++) begin
        s = str[k] ^ mPast[3] ^ mPast[8];
        mPast = {mPast[7:0], s};
        mLvl = mLvl ^ s;
        e[k] = mLvl;
      end
    end
  endtask

  // Called at a falling edge: drive, wait one clock, compare.
  task automatic runStep(input logic c, input logic w, input logic [19:0] d, input string req);
    logic [19:0] e;
    codeEn = c;
    wideMode = w;
    dataIn = d;
    modelWord(c, w, d, e);
    @(negedge clk);
    check(req, {serWide, serOut}, {w, e});
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", MAX_CYCLES, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [19:0] rw;
    logic [19:0] e;
    logic rc, rwide;
    void'($urandom(32'd1531));
    modelReset();

    // R1: outputs zero during reset, even with live inputs.
    codeEn = 1'b1; wideMode = 1'b1; dataIn = 20'hFFFFF;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {serWide, serOut}, 21'h0);
    rstN = 1'b1;

    // R1 R2: zeros from a cleared state stay zero.
    runStep(1'b1, 1'b0, 20'h00000, "R1 zero in zero out");
    runStep(1'b1, 1'b1, 20'h00000, "R1 wide zero in zero out");

    // R2 R3 R4: single 1 at stream bit 0 from clean state gives 0x10F.
    codeEn = 1'b1; wideMode = 1'b0; dataIn = 20'h00400;
    modelWord(1'b1, 1'b0, 20'h00400, e);
    @(negedge clk);
    check("R2 R3 R4 impulse", {serWide, serOut}, {1'b0, 20'h0010F});
    check("R2 model agrees impulse", {1'b0, e}, {1'b0, 20'h0010F});

    // R6: junk on the unused lower lane has no effect.
    runStep(1'b1, 1'b0, 20'h2A955, "R6 narrow low bits ignored");
    runStep(1'b1, 1'b0, 20'h2A8AA, "R6 narrow low bits ignored b");

    // R5 R9: wide words, continuing state across width change.
    runStep(1'b1, 1'b1, 20'h3FF00, "R5 R9 wide after narrow");
    runStep(1'b1, 1'b1, 20'h000FF, "R5 wide chroma first");

    // R7: data-through, narrow and wide.
    runStep(1'b0, 1'b0, 20'h12345, "R7 bypass narrow");
    runStep(1'b0, 1'b1, 20'hABCDE, "R7 bypass wide");
    runStep(1'b0, 1'b1, 20'hFFFFF, "R7 bypass ones");

    // R8: coding resumes from the pre-bypass state.
    runStep(1'b1, 1'b0, 20'h00000, "R8 resume after bypass");
    runStep(1'b1, 1'b1, 20'h55555, "R8 R9 resume wide");

    // Random mix of modes, widths and data (R2..R9).
    for (int i = 0; i < 400; i++) begin
      rc = ($urandom_range(0, 3) != 0);
      rwide = $urandom_range(0, 1);
      rw = $urandom();
      runStep(rc, rwide, rw, "R2 R3 R5 R6 R7 R8 R9 random");
    end

    // R1: reset mid-run clears the coding state.
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", {serWide, serOut}, 21'h0);
    rstN = 1'b1;
    modelReset();
    runStep(1'b1, 1'b1, 20'h00000, "R1 cleared state after reset");
    runStep(1'b1, 1'b0, 20'h00400, "R1 R3 impulse after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule